// File: doc/BRIEF.md
# Character Bridge FIFO Interrupt Controller

This block sits between a processor bus and a host link that carries a character stream in both directions. The processor writes characters into a transmit queue, and the host link drains that queue one character at a time. The host link fills a receive queue, and the processor drains it by reading the data register. Each queue keeps an occupancy count. The block turns those counts into one interrupt line.

There are two interrupt sources. The transmit-side source is pending while the transmit queue is nearly empty, so software knows it can refill it. The receive-side source is pending while the receive queue is nearly full, judged by how much free space is left. It is also pending while at least one character is waiting and the host has declared that nothing more is coming. Each source has its own enable bit. Software can read the raw pending state of both sources whatever the enables are. The thresholds are elaboration-time parameters and cannot be changed from the bus.

Top module: `char_bridge_irq`

## Requirements
- R1: After reset both queues are empty, both enable bits are 0 and `irq` is low. A control read then returns 0x0000_0100: only the transmit pending flag (bit 8) is set, because an empty transmit queue is below its threshold.
- R2: The transmit pending flag (control bit 8) is 1 whenever the transmit queue holds `WR_TH` (default 8) or fewer characters.
- R3: Once set, the transmit pending flag clears only when processor writes raise the transmit occupancy above `WR_TH`. A host-side drain that brings the occupancy back down sets the flag again.
- R4: The receive pending flag (control bit 9) is 1 whenever the receive queue has `RD_TH` (default 8) or fewer free entries, i.e. occupancy of at least `DEPTH-RD_TH` (56).
- R5: The receive pending flag is also 1 when the receive queue holds at least one character and `host_idle` was high at the previous clock edge. It takes effect one cycle after `host_idle` rises. It clears once processor reads have emptied the queue.
- R6: `irq` equals (transmit pending AND WE) OR (receive pending AND RE). WE is control bit 0 and RE is control bit 1, both readable and writable. Control read bit 10 mirrors `irq`. Both pending flags read back whatever the enable bits are.
- R7: A processor write to the data register (address 0) while the transmit queue holds `DEPTH` (64) characters is dropped. Exactly 64 characters then reach the host side.
- R8: A processor read of the data register while the receive queue is empty returns valid bit 15 = 0 and leaves the queue unchanged. The next character pushed is the next one read.
- R9: Each queue delivers characters in the order they were pushed. A data read returns the character in bits 7:0 with valid bit 15 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Processor write strobe |
| bus_rd | input | 1 | Processor read strobe. A data read pops the receive queue at the edge. |
| bus_addr | input | 1 | 0 = data register, 1 = control register |
| bus_wdata | input | DW (32) | Write data: character in bits 7:0, or WE in bit 0 and RE in bit 1 |
| bus_rdata | output | DW (32) | Combinational read data while `bus_rd` is high |
| host_tx_valid | output | 1 | Transmit queue is not empty |
| host_tx_data | output | CHW (8) | Oldest transmit character |
| host_tx_pop | input | 1 | Host takes one transmit character |
| host_rx_push | input | 1 | Host delivers one receive character |
| host_rx_data | input | CHW (8) | Character delivered by the host |
| host_rx_ready | output | 1 | Receive queue is not full |
| host_idle | input | 1 | Level: the host expects to send no more characters |
| irq | output | 1 | Combined interrupt request |

## Verification
The main check walks a table of queue states. Each state fills the transmit queue to a set level, fills the receive queue to a set level, sets `host_idle` and the two enables, and then compares both pending flags and `irq`. The levels sit on both sides of each threshold (8 against 9 transmit characters, 55 against 56 receive characters). This shows the limits are inclusive in the right direction, and that the receive side measures free space rather than fill.

Some entries raise `host_idle` with an empty receive queue and others with a single character waiting. These separate the idle term from the threshold term. Entries with a pending source but its enable off show that the flags are raw while `irq` is gated.

Directed sequences cover the rest:
- a write to a full transmit queue, followed by draining every character;
- a read of an empty receive queue, followed by a push;
- a transmit refill-and-drain around the threshold;
- the one-cycle delay of the idle term.

// File: rtl/cbi_pkg.sv
package cbi_pkg;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  localparam int unsigned BIT_WE     = 0;
  localparam int unsigned BIT_RE     = 1;
  localparam int unsigned BIT_WPEND  = 8;
  localparam int unsigned BIT_RPEND  = 9;
  localparam int unsigned BIT_IRQ    = 10;
  localparam int unsigned BIT_RVALID = 15;

  // Transmit side is low when occupancy is at or under its threshold.
  function automatic logic tx_low(input int unsigned occ, input int unsigned th);
    return occ <= th;
  endfunction

  function automatic int unsigned free_slots(input int unsigned depth, input int unsigned occ);
    return depth - occ;
  endfunction

  // Receive side needs service when space is scarce, or when data sits and the host is done.
  function automatic logic rx_service(input int unsigned depth, input int unsigned occ,
                                      input int unsigned th, input logic done);
    return (free_slots(depth, occ) <= th) || ((occ != 0) && done);
  endfunction

endpackage

// File: rtl/cbi_fifo.sv
module cbi_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CNTW = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [WIDTH-1:0] din,
  input  logic            pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNTW-1:0] occ,
  output logic            full,
  output logic            empty,
  output logic            push_ok,
  output logic            pop_ok
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;

  assign full    = (occ == CNTW'(DEPTH));
  assign empty   = (occ == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/cbi_irq.sv
module cbi_irq
  import cbi_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WR_TH = 8,
  parameter int unsigned RD_TH = 8,
  parameter int unsigned CNTW  = 7
) (
  input  logic [CNTW-1:0] tx_occ,
  input  logic [CNTW-1:0] rx_occ,
  input  logic            idle_q,
  input  logic            we,
  input  logic            re,
  output logic            wr_pend,
  output logic            rd_pend,
  output logic            irq
);

  always_comb begin
    wr_pend = tx_low(int'(tx_occ), WR_TH);
    rd_pend = rx_service(DEPTH, int'(rx_occ), RD_TH, idle_q);
    irq     = (wr_pend && we) || (rd_pend && re);
  end

endmodule

// File: rtl/char_bridge_irq.sv
module char_bridge_irq
  import cbi_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CHW   = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned WR_TH = 8,
  parameter int unsigned RD_TH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic           bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           host_tx_valid,
  output logic [CHW-1:0] host_tx_data,
  input  logic           host_tx_pop,
  input  logic           host_rx_push,
  input  logic [CHW-1:0] host_rx_data,
  output logic           host_rx_ready,
  input  logic           host_idle,
  output logic           irq
);

  localparam int unsigned CNTW = $clog2(DEPTH) + 1;

  logic            we_q, re_q, idle_q;
  logic            data_wr, data_rd, ctrl_wr;
  logic [CNTW-1:0] tx_occ, rx_occ;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic            tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic [CHW-1:0]  rx_dout;
  logic            wr_pend, rd_pend;

  assign data_wr = bus_wr && (reg_sel_e'(bus_addr) == SEL_DATA);
  assign ctrl_wr = bus_wr && (reg_sel_e'(bus_addr) == SEL_CTRL);
  assign data_rd = bus_rd && (reg_sel_e'(bus_addr) == SEL_DATA);

  cbi_fifo #(.DEPTH(DEPTH), .WIDTH(CHW)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(data_wr), .din(bus_wdata[CHW-1:0]),
    .pop(host_tx_pop), .dout(host_tx_data),
    .occ(tx_occ), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  cbi_fifo #(.DEPTH(DEPTH), .WIDTH(CHW)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(host_rx_push), .din(host_rx_data),
    .pop(data_rd), .dout(rx_dout),
    .occ(rx_occ), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  assign host_tx_valid = !tx_empty;
  assign host_rx_ready = !rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      re_q   <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      idle_q <= host_idle;
      if (ctrl_wr) begin
        we_q <= bus_wdata[BIT_WE];
        re_q <= bus_wdata[BIT_RE];
      end
    end
  end

  cbi_irq #(.DEPTH(DEPTH), .WR_TH(WR_TH), .RD_TH(RD_TH), .CNTW(CNTW)) u_irq (
    .tx_occ(tx_occ), .rx_occ(rx_occ), .idle_q(idle_q),
    .we(we_q), .re(re_q),
    .wr_pend(wr_pend), .rd_pend(rd_pend), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (reg_sel_e'(bus_addr) == SEL_DATA) begin
        bus_rdata[BIT_RVALID] = !rx_empty;
        if (!rx_empty) bus_rdata[CHW-1:0] = rx_dout;
      end else begin
        bus_rdata[BIT_WE]    = we_q;
        bus_rdata[BIT_RE]    = re_q;
        bus_rdata[BIT_WPEND] = wr_pend;
        bus_rdata[BIT_RPEND] = rd_pend;
        bus_rdata[BIT_IRQ]   = irq;
      end
    end
  end

endmodule

// File: rtl/cbi_checker.sv
module cbi_checker #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNTW  = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CNTW-1:0] tx_occ,
  input logic [CNTW-1:0] rx_occ,
  input logic            data_wr,
  input logic            data_rd,
  input logic            tx_pop,
  input logic            rx_push,
  input logic            host_idle,
  input logic            wr_pend,
  input logic            rd_pend,
  input logic            we_q,
  input logic            re_q,
  input logic            irq,
  input logic            rd_valid
);

  // R7: a full transmit queue without a host pop stays full, so pushes are dropped
  p_tx_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_occ == CNTW'(DEPTH)) && !tx_pop |=> (tx_occ == CNTW'(DEPTH)));

  // R3: transmit pending can only go away through a processor write
  p_wpend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend && !data_wr |=> wr_pend);

  // R5: host done with more than one character waiting means receive pending next cycle
  p_rpend_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_idle && (rx_occ > CNTW'(1)) |=> rd_pend);

  // R8: a read of an empty receive queue is flagged invalid
  p_empty_read_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_occ == '0) && data_rd |-> !rd_valid);

  // R8: a read of an empty receive queue leaves it empty
  p_empty_read_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_occ == '0) && data_rd && !rx_push |=> (rx_occ == '0));

  // R6: no interrupt without an enable
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (we_q || re_q));

endmodule

bind char_bridge_irq cbi_checker #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_occ(tx_occ), .rx_occ(rx_occ),
  .data_wr(data_wr), .data_rd(data_rd),
  .tx_pop(host_tx_pop), .rx_push(host_rx_push), .host_idle(host_idle),
  .wr_pend(wr_pend), .rd_pend(rd_pend),
  .we_q(we_q), .re_q(re_q), .irq(irq),
  .rd_valid(bus_rdata[cbi_pkg::BIT_RVALID])
);

// File: tb/sim_char_bridge_irq.sv
module sim_char_bridge_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        host_tx_valid;
  logic [7:0]  host_tx_data;
  logic        host_tx_pop = 1'b0, host_rx_push = 1'b0;
  logic [7:0]  host_rx_data = '0;
  logic        host_rx_ready;
  logic        host_idle = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  char_bridge_irq u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_tx_valid(host_tx_valid), .host_tx_data(host_tx_data), .host_tx_pop(host_tx_pop),
    .host_rx_push(host_rx_push), .host_rx_data(host_rx_data), .host_rx_ready(host_rx_ready),
    .host_idle(host_idle), .irq(irq)
  );

  // tx level, rx level, idle, WE, RE, expected wpend, rpend, irq
  typedef struct packed {
    logic [7:0] n_tx;
    logic [7:0] n_rx;
    logic idle, we, re, e_wp, e_rp, e_irq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd0,  8'd0,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{8'd8,  8'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'd9,  8'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd20, 8'd55, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd20, 8'd56, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{8'd20, 8'd1,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{8'd5,  8'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{8'd5,  8'd64, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'd64, 8'd3,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'd12, 8'd60, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; host_tx_pop = 1'b0;
    host_rx_push = 1'b0; host_idle = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic cpu_wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic host_push(input logic [7:0] d);
    @(negedge clk);
    host_rx_push = 1'b1; host_rx_data = d;
    @(posedge clk);
    #1 host_rx_push = 1'b0;
  endtask

  task automatic host_pop();
    @(negedge clk);
    host_tx_pop = 1'b1;
    @(posedge clk);
    #1 host_tx_pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;

    // R1: reset state
    do_reset();
    @(negedge clk);
    #1;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx_valid", {31'b0, host_tx_valid}, 32'h0);
    check("R1 rx_ready", {31'b0, host_rx_ready}, 32'h1);
    cpu_rd(1'b1, rd);
    check("R1 ctrl", rd, 32'h0000_0100);

    // R2 R4 R5 R6: table of queue states
    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int i = 0; i < int'(VECS[v].n_tx); i++) cpu_wr(1'b0, 32'(i));
      for (int i = 0; i < int'(VECS[v].n_rx); i++) host_push(8'(i));
      @(negedge clk);
      host_idle = VECS[v].idle;
      cpu_wr(1'b1, {30'b0, VECS[v].re, VECS[v].we});
      cpu_rd(1'b1, rd);
      check($sformatf("R2 wpend v%0d", v), {31'b0, rd[8]},  {31'b0, VECS[v].e_wp});
      check($sformatf("R4 R5 rpend v%0d", v), {31'b0, rd[9]}, {31'b0, VECS[v].e_rp});
      check($sformatf("R6 irq bit v%0d", v), {31'b0, rd[10]}, {31'b0, VECS[v].e_irq});
      check($sformatf("R6 enables v%0d", v), {30'b0, rd[1:0]}, {30'b0, VECS[v].re, VECS[v].we});
      #1 check($sformatf("R6 irq pin v%0d", v), {31'b0, irq}, {31'b0, VECS[v].e_irq});
    end

    // R7 R9: overfill the transmit queue, then drain it all
    do_reset();
    for (int i = 0; i < 65; i++) cpu_wr(1'b0, 32'(i + 8'h10));
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      #1;
      check("R7 tx_valid", {31'b0, host_tx_valid}, 32'h1);
      check("R9 tx order", {24'b0, host_tx_data}, 32'(i + 8'h10));
      host_pop();
    end
    @(negedge clk);
    #1 check("R7 dropped write", {31'b0, host_tx_valid}, 32'h0);

    // R3: transmit pending clears above threshold and returns after a drain
    do_reset();
    for (int i = 0; i < 8; i++) cpu_wr(1'b0, 32'(i));
    cpu_rd(1'b1, rd);
    check("R3 pend at 8", {31'b0, rd[8]}, 32'h1);
    cpu_wr(1'b0, 32'h55);
    cpu_rd(1'b1, rd);
    check("R3 clear at 9", {31'b0, rd[8]}, 32'h0);
    host_pop();
    cpu_rd(1'b1, rd);
    check("R3 set after drain", {31'b0, rd[8]}, 32'h1);

    // R8: empty receive read, then a push
    do_reset();
    cpu_rd(1'b0, rd);
    check("R8 empty read", rd, 32'h0);
    host_push(8'hA5);
    cpu_rd(1'b0, rd);
    check("R8 R9 read after push", rd, 32'h0000_80A5);
    cpu_rd(1'b0, rd);
    check("R8 empty again", rd, 32'h0);

    // R5: one-cycle delay of the idle term, then cleared by reads
    do_reset();
    host_push(8'h11);
    host_push(8'h22);
    cpu_wr(1'b1, 32'h2);
    @(negedge clk);
    host_idle = 1'b1; bus_rd = 1'b1; bus_addr = 1'b1;
    #1 check("R5 not yet", {31'b0, bus_rdata[9]}, 32'h0);
    @(negedge clk);
    #1 check("R5 after one cycle", {31'b0, bus_rdata[9]}, 32'h1);
    check("R5 irq", {31'b0, irq}, 32'h1);
    bus_rd = 1'b0;
    cpu_rd(1'b0, rd);
    cpu_rd(1'b1, rd);
    check("R5 one left", {31'b0, rd[9]}, 32'h1);
    cpu_rd(1'b0, rd);
    check("R9 second char", rd, 32'h0000_8022);
    cpu_rd(1'b1, rd);
    check("R5 cleared by reads", {31'b0, rd[9]}, 32'h0);
    #1 check("R5 irq low", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule